// File: doc/BRIEF.md
# Register Stack Frame Mapper

This block translates logical general-register numbers into physical register-file indices for a register stack kept per procedure. Logical registers 0 to 31 are shared by every procedure and pass straight through. Logical registers 32 and upward name the current procedure's frame. That frame is a window into a circular physical file of `NPHYS` stacked registers, and the window starts at a frame base pointer. Several read ports translate in parallel, all in combinational logic.

A command port takes three operations: allocate, call and return. Allocate sets the current frame's local and total sizes. Call saves the caller's frame sizes on an internal marker stack and moves the base past the caller's locals. The caller's outputs therefore become the first registers of the callee's frame. Return restores the caller's sizes and base exactly. The block counts how many registers of older frames still sit in the physical file. When a larger frame would overfill the file, the block first asks for the oldest resident registers to be spilled to a backing store. When a return finds the caller's locals no longer resident, it asks for them to be filled back. Each transfer is one register with a request/acknowledge handshake. The data movement itself happens outside the block.

Top module: `regstack_mapper`

## Requirements
- R1: A logical register below 32 maps to the same number on its port and never raises the illegal flag.
- R2: A logical register r of 32 or more, inside the frame, maps to 32 + ((base + r - 32) mod NPHYS). The index wraps around the physical file.
- R3: The illegal flag is raised for a logical register r of 32 or more when r - 32 is greater than or equal to the current frame size.
- R4: Allocate (cmd_op = 0) sets the frame's local count from cmd_locals and its total size from cmd_frame. It is ignored when cmd_frame exceeds MAX_FRAME or cmd_locals exceeds cmd_frame. Operation code 3 does nothing.
- R5: Call (cmd_op = 1) moves the base forward by the caller's local count. The new frame holds only the caller's outputs, now numbered from logical 32.
- R6: Return (cmd_op = 2) restores the caller's local count, frame size and base. A return with no saved frame is ignored.
- R7: An allocate that would make resident older registers plus the new frame exceed NPHYS raises xfer_spill once for each excess register. The requests go oldest first, at consecutive physical indices starting at 32 + ((base - resident) mod NPHYS). cmd_ready is low meanwhile, and the new sizes apply after the last acknowledge.
- R8: A return whose caller local count exceeds the resident older registers raises xfer_fill once for each missing register. The requests go youngest first, at descending physical indices starting at 32 + ((base - resident - 1) mod NPHYS). The caller frame applies after the last acknowledge.
- R9: A spill or fill request holds its index unchanged until xfer_ack is seen. Spill and fill are never raised together.
- R10: A call is ignored when DEPTH frames are already saved.
- R11: After reset the frame size and base are zero, no transfer is requested and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is high |
| cmd_op | input | 2 | 0 allocate, 1 call, 2 return, 3 no operation |
| cmd_locals | input | SZ_W | Local count for allocate |
| cmd_frame | input | SZ_W | Total frame size for allocate |
| cmd_ready | output | 1 | High when no transfer sequence is in progress |
| lreg | input | NPORTS*LREG_W | Logical register number for each read port |
| preg | output | NPORTS*PREG_W | Physical index for each read port |
| illegal | output | NPORTS | Logical register outside the current frame, per port |
| xfer_spill | output | 1 | Request to save one register to the backing store |
| xfer_fill | output | 1 | Request to reload one register from the backing store |
| xfer_reg | output | PREG_W | Physical index of the register to transfer |
| xfer_ack | input | 1 | Transfer of the requested register completed |

## Verification
The assertions assume that NPHYS is at least MAX_FRAME. They also assume that every logical register number on port 0 is a known value, since port 0 is the one checked each cycle against the pass-through and range rules. The ordering checks assume that xfer_ack matters only while a request is up. The stimulus raises the acknowledge only after it has seen a request, and drops it right after the edge that took it. Commands are sent only while cmd_ready is high, and allocation sizes stay within the 7-bit fields, apart from the deliberately rejected cases.

// File: rtl/rsmap_pkg.sv
package rsmap_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_NOP   = 2'd3
  } rs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } rs_state_e;

  localparam int unsigned GLOBAL_REGS = 32;
endpackage

// File: rtl/rsmap_lookup.sv
module rsmap_lookup #(
  parameter int unsigned NPHYS  = 128,
  parameter int unsigned LREG_W = 7,
  parameter int unsigned SZ_W   = 7,
  parameter int unsigned BOF_W  = 7,
  parameter int unsigned PREG_W = 8
) (
  input  logic [LREG_W-1:0] lreg,
  input  logic [BOF_W-1:0]  bof,
  input  logic [SZ_W-1:0]   sof,
  output logic [PREG_W-1:0] preg,
  output logic              illegal
);
  import rsmap_pkg::*;

  localparam int unsigned CW = 16;

  logic          in_stack;
  logic [CW-1:0] offset;
  logic [CW-1:0] slot;

  always_comb begin
    in_stack = (CW'(lreg) >= CW'(GLOBAL_REGS));
    offset   = CW'(lreg) - CW'(GLOBAL_REGS);
    slot     = CW'(bof) + offset;
    if (slot >= CW'(NPHYS)) begin
      slot = slot - CW'(NPHYS);
    end
    illegal = in_stack && (offset >= CW'(sof));
    if (in_stack) begin
      preg = PREG_W'(slot + CW'(GLOBAL_REGS));
    end else begin
      preg = PREG_W'(lreg);
    end
  end
endmodule

// File: rtl/rsmap_lifo.sv
module rsmap_lifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SZ_W  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [SZ_W-1:0] push_sol,
  input  logic [SZ_W-1:0] push_sof,
  output logic [SZ_W-1:0] top_sol,
  output logic [SZ_W-1:0] top_sof,
  output logic            full,
  output logic            empty
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);
  localparam int unsigned IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SZ_W-1:0] mem_sol [DEPTH];
  logic [SZ_W-1:0] mem_sof [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_d;
  logic [IX_W-1:0] top_ix;
  logic [IX_W-1:0] wr_ix;

  always_comb begin
    sp_d = sp_q;
    if (push && !full) begin
      sp_d = sp_q + SP_W'(1);
    end else if (pop && !empty) begin
      sp_d = sp_q - SP_W'(1);
    end
  end

  always_comb begin
    wr_ix  = IX_W'(sp_q);
    top_ix = (sp_q == '0) ? '0 : IX_W'(sp_q - SP_W'(1));
  end

  assign full    = (sp_q == SP_W'(DEPTH));
  assign empty   = (sp_q == '0);
  assign top_sol = mem_sol[top_ix];
  assign top_sof = mem_sof[top_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem_sol[wr_ix] <= push_sol;
      mem_sof[wr_ix] <= push_sof;
    end
  end
endmodule

// File: rtl/rsmap_ctrl.sv
module rsmap_ctrl #(
  parameter int unsigned NPHYS     = 128,
  parameter int unsigned MAX_FRAME = 96,
  parameter int unsigned SZ_W      = 7,
  parameter int unsigned BOF_W     = 7,
  parameter int unsigned PREG_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SZ_W-1:0]   cmd_locals,
  input  logic [SZ_W-1:0]   cmd_frame,
  output logic              cmd_ready,
  input  logic [SZ_W-1:0]   top_sol,
  input  logic [SZ_W-1:0]   top_sof,
  input  logic              stk_full,
  input  logic              stk_empty,
  output logic              stk_push,
  output logic              stk_pop,
  output logic [SZ_W-1:0]   cur_sol,
  output logic [SZ_W-1:0]   cur_sof,
  output logic [BOF_W-1:0]  cur_bof,
  output logic              xfer_spill,
  output logic              xfer_fill,
  output logic [PREG_W-1:0] xfer_reg,
  input  logic              xfer_ack
);
  import rsmap_pkg::*;

  localparam int unsigned CW   = 16;
  localparam int unsigned DC_W = $clog2(NPHYS + 1);

  function automatic logic [BOF_W-1:0] ring_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] s;
    s = a + b;
    if (s >= CW'(NPHYS)) s = s - CW'(NPHYS);
    return BOF_W'(s);
  endfunction

  function automatic logic [BOF_W-1:0] ring_sub(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] s;
    s = a + CW'(NPHYS) - b;
    if (s >= CW'(NPHYS)) s = s - CW'(NPHYS);
    return BOF_W'(s);
  endfunction

  rs_state_e       st_q, st_d;
  rs_op_e          op;
  logic [BOF_W-1:0] bof_q, bof_d;
  logic [SZ_W-1:0]  sol_q, sol_d, sof_q, sof_d;
  logic [SZ_W-1:0]  psol_q, psol_d, psof_q, psof_d;
  logic [DC_W-1:0]  nd_q, nd_d, cnt_q, cnt_d, nd_inc;
  logic [CW-1:0]    need;

  assign op     = rs_op_e'(cmd_op);
  assign nd_inc = nd_q + DC_W'(1);

  always_comb begin
    st_d     = st_q;
    bof_d    = bof_q;
    sol_d    = sol_q;
    sof_d    = sof_q;
    nd_d     = nd_q;
    cnt_d    = cnt_q;
    psol_d   = psol_q;
    psof_d   = psof_q;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    need     = CW'(nd_q) + CW'(cmd_frame);
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_ALLOC: begin
              if ((CW'(cmd_frame) <= CW'(MAX_FRAME)) && (cmd_locals <= cmd_frame)) begin
                if (need > CW'(NPHYS)) begin
                  st_d   = ST_SPILL;
                  cnt_d  = DC_W'(need - CW'(NPHYS));
                  psol_d = cmd_locals;
                  psof_d = cmd_frame;
                end else begin
                  sol_d = cmd_locals;
                  sof_d = cmd_frame;
                end
              end
            end
            OP_CALL: begin
              if (!stk_full) begin
                stk_push = 1'b1;
                bof_d    = ring_add(CW'(bof_q), CW'(sol_q));
                nd_d     = nd_q + DC_W'(sol_q);
                sof_d    = sof_q - sol_q;
                sol_d    = '0;
              end
            end
            OP_RET: begin
              if (!stk_empty) begin
                if (DC_W'(top_sol) > nd_q) begin
                  st_d  = ST_FILL;
                  cnt_d = DC_W'(top_sol) - nd_q;
                end else begin
                  stk_pop = 1'b1;
                  bof_d   = ring_sub(CW'(bof_q), CW'(top_sol));
                  nd_d    = nd_q - DC_W'(top_sol);
                  sol_d   = top_sol;
                  sof_d   = top_sof;
                end
              end
            end
            default: ;
          endcase
        end
      end
      ST_SPILL: begin
        if (xfer_ack) begin
          nd_d = nd_q - DC_W'(1);
          if (cnt_q == DC_W'(1)) begin
            sol_d = psol_q;
            sof_d = psof_q;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q - DC_W'(1);
          end
        end
      end
      ST_FILL: begin
        if (xfer_ack) begin
          if (cnt_q == DC_W'(1)) begin
            stk_pop = 1'b1;
            bof_d   = ring_sub(CW'(bof_q), CW'(top_sol));
            nd_d    = nd_inc - DC_W'(top_sol);
            sol_d   = top_sol;
            sof_d   = top_sof;
            st_d    = ST_IDLE;
          end else begin
            nd_d  = nd_inc;
            cnt_d = cnt_q - DC_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bof_q  <= '0;
      sol_q  <= '0;
      sof_q  <= '0;
      nd_q   <= '0;
      cnt_q  <= '0;
      psol_q <= '0;
      psof_q <= '0;
    end else begin
      st_q   <= st_d;
      bof_q  <= bof_d;
      sol_q  <= sol_d;
      sof_q  <= sof_d;
      nd_q   <= nd_d;
      cnt_q  <= cnt_d;
      psol_q <= psol_d;
      psof_q <= psof_d;
    end
  end

  always_comb begin
    cmd_ready  = (st_q == ST_IDLE);
    xfer_spill = (st_q == ST_SPILL);
    xfer_fill  = (st_q == ST_FILL);
    if (st_q == ST_FILL) begin
      xfer_reg = PREG_W'(CW'(ring_sub(CW'(bof_q), CW'(nd_inc))) + CW'(GLOBAL_REGS));
    end else begin
      xfer_reg = PREG_W'(CW'(ring_sub(CW'(bof_q), CW'(nd_q))) + CW'(GLOBAL_REGS));
    end
    cur_sol = sol_q;
    cur_sof = sof_q;
    cur_bof = bof_q;
  end
endmodule

// File: rtl/regstack_mapper.sv
module regstack_mapper #(
  parameter int unsigned NPHYS     = 128,
  parameter int unsigned MAX_FRAME = 96,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned NPORTS    = 2,
  parameter int unsigned LREG_W    = 7,
  parameter int unsigned SZ_W      = $clog2(MAX_FRAME + 1),
  parameter int unsigned PREG_W    = $clog2(32 + NPHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [SZ_W-1:0]          cmd_locals,
  input  logic [SZ_W-1:0]          cmd_frame,
  output logic                     cmd_ready,
  input  logic [NPORTS*LREG_W-1:0] lreg,
  output logic [NPORTS*PREG_W-1:0] preg,
  output logic [NPORTS-1:0]        illegal,
  output logic                     xfer_spill,
  output logic                     xfer_fill,
  output logic [PREG_W-1:0]        xfer_reg,
  input  logic                     xfer_ack
);
  localparam int unsigned BOF_W = $clog2(NPHYS);

  logic [SZ_W-1:0]  top_sol, top_sof, cur_sol, cur_sof;
  logic [BOF_W-1:0] cur_bof;
  logic             stk_full, stk_empty, stk_push, stk_pop;

  rsmap_ctrl #(
    .NPHYS(NPHYS), .MAX_FRAME(MAX_FRAME), .SZ_W(SZ_W), .BOF_W(BOF_W), .PREG_W(PREG_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_locals(cmd_locals), .cmd_frame(cmd_frame),
    .cmd_ready(cmd_ready),
    .top_sol(top_sol), .top_sof(top_sof), .stk_full(stk_full), .stk_empty(stk_empty),
    .stk_push(stk_push), .stk_pop(stk_pop),
    .cur_sol(cur_sol), .cur_sof(cur_sof), .cur_bof(cur_bof),
    .xfer_spill(xfer_spill), .xfer_fill(xfer_fill), .xfer_reg(xfer_reg), .xfer_ack(xfer_ack)
  );

  rsmap_lifo #(.DEPTH(DEPTH), .SZ_W(SZ_W)) lifo_i (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .push_sol(cur_sol), .push_sof(cur_sof),
    .top_sol(top_sol), .top_sof(top_sof), .full(stk_full), .empty(stk_empty)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    rsmap_lookup #(
      .NPHYS(NPHYS), .LREG_W(LREG_W), .SZ_W(SZ_W), .BOF_W(BOF_W), .PREG_W(PREG_W)
    ) lookup_i (
      .lreg(lreg[g*LREG_W +: LREG_W]),
      .bof(cur_bof),
      .sof(cur_sof),
      .preg(preg[g*PREG_W +: PREG_W]),
      .illegal(illegal[g])
    );
  end
endmodule

// File: rtl/regstack_mapper_chk.sv
module regstack_mapper_chk #(
  parameter int unsigned NPHYS  = 128,
  parameter int unsigned LREG_W = 7,
  parameter int unsigned PREG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              xfer_spill,
  input logic              xfer_fill,
  input logic [PREG_W-1:0] xfer_reg,
  input logic              xfer_ack,
  input logic [LREG_W-1:0] lreg0,
  input logic [PREG_W-1:0] preg0,
  input logic              illegal0
);
  function automatic int unsigned step_ring(input int unsigned r, input int unsigned up);
    int unsigned o;
    o = r - 32;
    if (up != 0) o = (o + 1) % NPHYS;
    else         o = (o + NPHYS - 1) % NPHYS;
    return o + 32;
  endfunction

  assert_global_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg0 < LREG_W'(32)) |-> (preg0 == PREG_W'(lreg0)) && !illegal0);

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lreg0 >= LREG_W'(32)) && !illegal0) |->
      (int'(preg0) >= 32) && (int'(preg0) < 32 + int'(NPHYS)));

  assert_no_cmd_during_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_spill || xfer_fill) |-> !cmd_ready);

  assert_spill_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_spill && $past(xfer_spill && xfer_ack)) |->
      (int'(xfer_reg) == int'(step_ring(int'($past(xfer_reg)), 1))));

  assert_fill_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fill && $past(xfer_fill && xfer_ack)) |->
      (int'(xfer_reg) == int'(step_ring(int'($past(xfer_reg)), 0))));

  assert_spill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_spill && !xfer_ack) |=> xfer_spill && $stable(xfer_reg));

  assert_fill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fill && !xfer_ack) |=> xfer_fill && $stable(xfer_reg));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_spill, xfer_fill}));
endmodule

bind regstack_mapper regstack_mapper_chk #(
  .NPHYS(NPHYS), .LREG_W(LREG_W), .PREG_W(PREG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .xfer_spill(xfer_spill), .xfer_fill(xfer_fill), .xfer_reg(xfer_reg), .xfer_ack(xfer_ack),
  .lreg0(lreg[LREG_W-1:0]), .preg0(preg[PREG_W-1:0]), .illegal0(illegal[0])
);

// File: tb/regstack_mapper_tb_top.sv
module regstack_mapper_tb_top;
  localparam int N = 128;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [6:0]  cmd_locals;
  logic [6:0]  cmd_frame;
  logic        cmd_ready;
  logic [13:0] lreg;
  logic [15:0] preg;
  logic [1:0]  illegal;
  logic        xfer_spill;
  logic        xfer_fill;
  logic [7:0]  xfer_reg;
  logic        xfer_ack;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  regstack_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_locals(cmd_locals), .cmd_frame(cmd_frame), .cmd_ready(cmd_ready),
    .lreg(lreg), .preg(preg), .illegal(illegal),
    .xfer_spill(xfer_spill), .xfer_fill(xfer_fill), .xfer_reg(xfer_reg), .xfer_ack(xfer_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int loc, input int frm);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_locals = 7'(loc);
    cmd_frame  = 7'(frm);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  // exp_p < 0 skips the index comparison
  task automatic probe(input int port, input int lr, input int exp_p, input bit exp_ill, input string tag);
    int got_p;
    if (port == 0) lreg[6:0] = 7'(lr);
    else           lreg[13:7] = 7'(lr);
    #1;
    got_p = (port == 0) ? int'(preg[7:0]) : int'(preg[15:8]);
    check(illegal[port] == exp_ill, {tag, " illegal flag"}, int'(illegal[port]), int'(exp_ill));
    if (exp_p >= 0) check(got_p == exp_p, {tag, " physical index"}, got_p, exp_p);
  endtask

  task automatic serve(input bit spill, input int first, input int count, input int step,
                       input int stall, input string tag);
    for (int i = 0; i < count; i++) begin
      int exp_r;
      exp_r = 32 + (((first - 32) + step * i + 4 * N) % N);
      check((spill ? xfer_spill : xfer_fill) == 1'b1, {tag, " request up"}, 0, 1);
      check((spill ? xfer_fill : xfer_spill) == 1'b0, {tag, " other request low"}, 1, 0);
      check(int'(xfer_reg) == exp_r, {tag, " transfer index"}, int'(xfer_reg), exp_r);
      check(cmd_ready == 1'b0, {tag, " ready low while busy"}, int'(cmd_ready), 0);
      if (i == 0) begin
        for (int s = 0; s < stall; s++) begin
          @(posedge clk);
          #1;
          check((spill ? xfer_spill : xfer_fill) == 1'b1, "R9 request held without ack", 0, 1);
          check(int'(xfer_reg) == exp_r, "R9 index stable without ack", int'(xfer_reg), exp_r);
        end
      end
      xfer_ack = 1'b1;
      @(posedge clk);
      #1;
      xfer_ack = 1'b0;
    end
    check(!xfer_spill && !xfer_fill, {tag, " requests cleared"}, int'({xfer_spill, xfer_fill}), 0);
    check(cmd_ready == 1'b1, {tag, " ready again"}, int'(cmd_ready), 1);
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R11 ready after reset", int'(cmd_ready), 1);
    check(!xfer_spill && !xfer_fill, "R11 no request after reset", int'({xfer_spill, xfer_fill}), 0);
    probe(0, 32, -1, 1'b1, "R11 empty frame");
    probe(0, 7, 7, 1'b0, "R1 global at reset");
  endtask

  task automatic t_alloc_call;
    send(2'd0, 10, 14);
    probe(0, 32, 32, 1'b0, "R4 R2 first stacked");
    probe(1, 45, 45, 1'b0, "R4 last in frame");
    probe(0, 46, -1, 1'b1, "R3 first past frame");
    probe(1, 31, 31, 1'b0, "R1 global 31");
    send(2'd1, 0, 0);
    probe(0, 32, 42, 1'b0, "R5 callee starts at caller outputs");
    probe(1, 35, 45, 1'b0, "R5 last caller output");
    probe(0, 36, -1, 1'b1, "R5 R3 callee frame size");
    send(2'd0, 90, 96);
    probe(0, 127, 137, 1'b0, "R4 R2 full size frame");
  endtask

  task automatic t_spill;
    send(2'd1, 0, 0);
    probe(0, 32, 132, 1'b0, "R5 second call base");
    probe(1, 37, 137, 1'b0, "R5 second call outputs");
    probe(0, 38, -1, 1'b1, "R3 second callee size");
    send(2'd0, 40, 40);
    serve(1'b1, 32, 12, 1, 2, "R7 spill");
    probe(0, 32, 132, 1'b0, "R7 base kept after spill");
    probe(1, 71, 43, 1'b0, "R2 R7 wrapped index after spill");
    probe(0, 72, -1, 1'b1, "R7 new size applied");
  endtask

  task automatic t_fill;
    send(2'd2, 0, 0);
    serve(1'b0, 43, 2, -1, 1, "R8 fill first return");
    probe(0, 32, 42, 1'b0, "R6 base restored");
    probe(1, 127, 137, 1'b0, "R6 size restored");
    send(2'd2, 0, 0);
    serve(1'b0, 41, 10, -1, 0, "R8 fill second return");
    probe(0, 45, 45, 1'b0, "R6 outer frame back");
    probe(1, 46, -1, 1'b1, "R6 outer size");
  endtask

  task automatic t_ignored;
    send(2'd2, 0, 0);
    check(cmd_ready == 1'b1 && !xfer_fill, "R6 empty return no fill", int'(xfer_fill), 0);
    probe(0, 45, 45, 1'b0, "R6 empty return ignored");
    probe(0, 46, -1, 1'b1, "R6 empty return size kept");
    send(2'd0, 5, 97);
    probe(0, 46, -1, 1'b1, "R4 oversize alloc ignored");
    probe(1, 45, 45, 1'b0, "R4 oversize alloc keeps frame");
    send(2'd0, 20, 10);
    probe(0, 46, -1, 1'b1, "R4 locals above size ignored");
    send(2'd3, 50, 60);
    probe(0, 46, -1, 1'b1, "R4 no-op code ignored");
    probe(1, 45, 45, 1'b0, "R4 no-op keeps base");
  endtask

  task automatic t_full_stack;
    for (int k = 0; k < 16; k++) begin
      send(2'd0, 1, 2);
      send(2'd1, 0, 0);
    end
    probe(1, 32, 48, 1'b0, "R5 sixteen calls base");
    send(2'd0, 1, 2);
    send(2'd1, 0, 0);
    probe(1, 33, 49, 1'b0, "R10 call on full stack ignored");
    probe(0, 34, -1, 1'b1, "R10 frame size unchanged");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 2'd3;
    cmd_locals = '0;
    cmd_frame  = '0;
    lreg       = '0;
    xfer_ack   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_alloc_call();
    t_spill();
    t_fill();
    t_ignored();
    t_full_stack();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule